// File: doc/BRIEF.md
# Stand-alone Learn/Erase Button Sequencer

This block runs a receiver that has no host controller. A single push button sits on the serial clock line, and the serial data line drives an LED or a relay. The block filters the button level and measures how long the button is held. It lights the LED while a press is still too short to act on. It turns the LED off once releasing the button would start a learn session. A much longer hold issues an erase of all stored transmitters. While learn is running, the block supervises the session and ends it on a button press, a non-sequential code, or a timeout. When no learn is in progress, it pulses the relay output after each valid transmission.

Time is measured in ticks of a 1 ms strobe, `ms_tick`. Every duration is a parameter expressed in ticks: debounce 20, learn hold 2000, additional erase hold 6000, relay 500 and learn timeout 30000. Learn itself, meaning key derivation and storage, happens elsewhere. This block only issues `learn_start`, `erase_all` and `learn_abort` as single-cycle pulses. It takes in two strobes that report learn progress: acceptable code and bad code.

Top module: `bsq_button_seq`

## Requirements
- R1: A change of the button level takes effect only after it has persisted, once synchronised, for `DEBOUNCE_MS` consecutive ticks. A shorter glitch leaves every output unchanged.
- R2: A debounced press from idle, or during a relay pulse, drives `data_drive` high.
- R3: A release within `LEARN_HOLD_MS` ticks of the press returns to idle with `data_drive` low and no pulse on any request output.
- R4: After `LEARN_HOLD_MS` ticks of holding, `data_drive` goes low. A release after that point and before the erase threshold produces one `learn_start` pulse and begins a learn session.
- R5: Holding for a further `ERASE_HOLD_MS` ticks produces one `erase_all` pulse with `data_drive` low. The later release starts no learn session.
- R6: A `rx_valid` strobe in idle drives `data_drive` high for exactly `RELAY_MS` ticks.
- R7: `rx_valid` has no effect during a learn session or while the button is held.
- R8: A debounced press during learn gives one `learn_abort` pulse. `data_drive` then stays high until the button is released, after which the block returns to idle.
- R9: A `lrn_code_bad` strobe during learn ends the session with one `learn_abort` pulse.
- R10: If a second `lrn_code_ok` has not arrived within `LEARN_TIMEOUT_MS` ticks of the learn start, the session ends with one `learn_abort` pulse.
- R11: A second `lrn_code_ok` in one session ends it without `learn_abort`. After that, relay operation works again.
- R12: `learn_start`, `erase_all` and `learn_abort` are single-cycle pulses, and no two of them are ever high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle strobe each millisecond |
| btn_in | input | 1 | Raw button level (clock line), high when pressed |
| rx_valid | input | 1 | Strobe: valid transmission decoded |
| lrn_code_ok | input | 1 | Strobe: acceptable code received during learn |
| lrn_code_bad | input | 1 | Strobe: non-sequential code received during learn |
| data_drive | output | 1 | LED / relay drive on the data line |
| learn_start | output | 1 | Pulse: begin a learn session |
| erase_all | output | 1 | Pulse: erase all transmitters |
| learn_abort | output | 1 | Pulse: learn session ended unsuccessfully |

## Verification
A button edge reaches the debounced level only after the synchroniser stages plus `DEBOUNCE_MS` ticks. The sequencer then acts on it one clock later. A duration threshold or a strobe changes `data_drive` and the request pulses at the clock edge where the deciding tick or strobe is sampled. Elapsed ticks are counted from the edge at which the current state was entered. The bench runs its own behavioural model on the same rising edges and compares all four outputs on every falling edge, so each check sits at the cycle where the result is due. Directed checks then count the pulses seen per scenario and probe `data_drive` after strobes that must be ignored.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE       = 3'd0,
      ST_RELAY      = 3'd1,
      ST_HOLD_SHORT = 3'd2,
      ST_HOLD_ARM   = 3'd3,
      ST_HOLD_DONE  = 3'd4,
      ST_LEARN      = 3'd5,
      ST_ABORT_WAIT = 3'd6
   } bsq_state_e;

   function automatic int bsq_max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/bsq_debounce.sv
module bsq_debounce #(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_TICKS   = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic btn_raw,
   output logic press,
   output logic rel
);
   localparam int DW = (DEB_TICKS < 2) ? 1 : $clog2(DEB_TICKS);

   logic          btn_s;
   logic          level;
   logic [DW-1:0] dcnt;

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (DEB_TICKS < 1) begin : g_bad_deb
         $error("DEB_TICKS must be at least 1");
      end
      if (SYNC_STAGES == 1) begin : g_sync_one
         logic s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= 1'b0;
            else        s_q <= btn_raw;
         end
         assign btn_s = s_q;
      end else begin : g_sync_chain
         logic [SYNC_STAGES-1:0] s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= {s_q[SYNC_STAGES-2:0], btn_raw};
         end
         assign btn_s = s_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= 1'b0;
         dcnt  <= '0;
         press <= 1'b0;
         rel   <= 1'b0;
      end else begin
         press <= 1'b0;
         rel   <= 1'b0;
         if (btn_s == level) begin
            dcnt <= '0;
         end else if (tick) begin
            if (dcnt == DW'(DEB_TICKS - 1)) begin
               level <= btn_s;
               press <= btn_s;
               rel   <= !btn_s;
               dcnt  <= '0;
            end else begin
               dcnt <= dcnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/bsq_tick_timer.sv
module bsq_tick_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         tick,
   input  logic [W-1:0] limit,
   output logic         hit
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
   end

   assign hit = tick && (cnt == limit - W'(1));

endmodule

// File: rtl/bsq_button_seq.sv
module bsq_button_seq
   import bsq_pkg::*;
#(
   parameter int SYNC_STAGES      = 2,
   parameter int DEBOUNCE_MS      = 20,
   parameter int LEARN_HOLD_MS    = 2000,
   parameter int ERASE_HOLD_MS    = 6000,
   parameter int RELAY_MS         = 500,
   parameter int LEARN_TIMEOUT_MS = 30000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ms_tick,
   input  logic btn_in,
   input  logic rx_valid,
   input  logic lrn_code_ok,
   input  logic lrn_code_bad,
   output logic data_drive,
   output logic learn_start,
   output logic erase_all,
   output logic learn_abort
);
   localparam int MAXV = bsq_max4(LEARN_HOLD_MS, ERASE_HOLD_MS, RELAY_MS, LEARN_TIMEOUT_MS);
   localparam int CW   = $clog2(MAXV + 1);

   generate
      if (LEARN_HOLD_MS < 1 || ERASE_HOLD_MS < 1 || RELAY_MS < 1 || LEARN_TIMEOUT_MS < 1) begin : g_bad_dur
         $error("all durations must be at least one tick");
      end
   endgenerate

   bsq_state_e    state_q, state_d;
   logic          press, rel, hit, ok_seen_q;
   logic          start_d, erase_d, abort_d;
   logic [CW-1:0] limit;

   bsq_debounce #(.SYNC_STAGES(SYNC_STAGES), .DEB_TICKS(DEBOUNCE_MS)) u_deb (
      .clk(clk), .rst_n(rst_n), .tick(ms_tick), .btn_raw(btn_in),
      .press(press), .rel(rel)
   );

   always_comb begin
      case (state_q)
         ST_RELAY:      limit = CW'(RELAY_MS);
         ST_HOLD_SHORT: limit = CW'(LEARN_HOLD_MS);
         ST_HOLD_ARM:   limit = CW'(ERASE_HOLD_MS);
         ST_LEARN:      limit = CW'(LEARN_TIMEOUT_MS);
         default:       limit = '1;
      endcase
   end

   bsq_tick_timer #(.W(CW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clr(state_d != state_q), .tick(ms_tick),
      .limit(limit), .hit(hit)
   );

   always_comb begin
      state_d = state_q;
      start_d = 1'b0;
      erase_d = 1'b0;
      abort_d = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (press)         state_d = ST_HOLD_SHORT;
            else if (rx_valid) state_d = ST_RELAY;
         end
         ST_RELAY: begin
            if (press)    state_d = ST_HOLD_SHORT;
            else if (hit) state_d = ST_IDLE;
         end
         ST_HOLD_SHORT: begin
            if (rel)      state_d = ST_IDLE;
            else if (hit) state_d = ST_HOLD_ARM;
         end
         ST_HOLD_ARM: begin
            if (rel) begin
               state_d = ST_LEARN;
               start_d = 1'b1;
            end else if (hit) begin
               state_d = ST_HOLD_DONE;
               erase_d = 1'b1;
            end
         end
         ST_HOLD_DONE: begin
            if (rel) state_d = ST_IDLE;
         end
         ST_LEARN: begin
            if (press) begin
               state_d = ST_ABORT_WAIT;
               abort_d = 1'b1;
            end else if (lrn_code_bad) begin
               state_d = ST_IDLE;
               abort_d = 1'b1;
            end else if (lrn_code_ok && ok_seen_q) begin
               state_d = ST_IDLE;
            end else if (hit) begin
               state_d = ST_IDLE;
               abort_d = 1'b1;
            end
         end
         ST_ABORT_WAIT: begin
            if (rel) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         ok_seen_q   <= 1'b0;
         learn_start <= 1'b0;
         erase_all   <= 1'b0;
         learn_abort <= 1'b0;
      end else begin
         state_q     <= state_d;
         learn_start <= start_d;
         erase_all   <= erase_d;
         learn_abort <= abort_d;
         if (state_q != ST_LEARN)  ok_seen_q <= 1'b0;
         else if (lrn_code_ok)     ok_seen_q <= 1'b1;
      end
   end

   assign data_drive = (state_q == ST_RELAY) || (state_q == ST_HOLD_SHORT) ||
                       (state_q == ST_ABORT_WAIT);

endmodule

// File: rtl/bsq_button_seq_chk.sv
module bsq_button_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic data_drive,
   input logic learn_start,
   input logic erase_all,
   input logic learn_abort
);
   assert_pulse_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({learn_start, erase_all, learn_abort}));

   assert_start_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
      learn_start |=> !learn_start);

   assert_erase_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
      erase_all |=> !erase_all);

   assert_abort_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
      learn_abort |=> !learn_abort);

   assert_start_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
      learn_start |-> !data_drive);

   assert_erase_dark_R5: assert property (@(posedge clk) disable iff (!rst_n)
      erase_all |-> !data_drive);

   assert_start_stays_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
      learn_start |=> !data_drive);

endmodule

bind bsq_button_seq bsq_button_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .data_drive(data_drive),
   .learn_start(learn_start), .erase_all(erase_all), .learn_abort(learn_abort)
);

// File: tb/tb_bsq_button_seq.sv
module tb_bsq_button_seq;
   localparam int P_DEB = 3, P_HOLD = 10, P_ERASE = 20, P_RELAY = 5, P_TMO = 40;

   logic clk = 1'b0, rst_n = 1'b0, ms_tick = 1'b0, btn_in = 1'b0;
   logic rx_valid = 1'b0, lrn_code_ok = 1'b0, lrn_code_bad = 1'b0;
   logic data_drive, learn_start, erase_all, learn_abort;
   int checks = 0, failures = 0;
   int n_ls = 0, n_ea = 0, n_la = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   bsq_button_seq #(.DEBOUNCE_MS(P_DEB), .LEARN_HOLD_MS(P_HOLD), .ERASE_HOLD_MS(P_ERASE),
                    .RELAY_MS(P_RELAY), .LEARN_TIMEOUT_MS(P_TMO)) dut (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .btn_in(btn_in), .rx_valid(rx_valid),
      .lrn_code_ok(lrn_code_ok), .lrn_code_bad(lrn_code_bad), .data_drive(data_drive),
      .learn_start(learn_start), .erase_all(erase_all), .learn_abort(learn_abort));

   always @(negedge clk) ms_tick <= ~ms_tick;

   // behavioural reference: 0 idle,1 relay,2 short,3 armed,4 erased,5 learn,6 abort wait
   bit m_s1, m_s2, m_lvl, m_pr, m_rl, m_ok, e_ls, e_ea, e_la;
   int m_dc, m_st, m_el;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_lvl = 0; m_pr = 0; m_rl = 0; m_ok = 0;
         e_ls = 0; e_ea = 0; e_la = 0; m_dc = 0; m_st = 0; m_el = 0;
      end else begin
         int nst, lim;
         bit due;
         nst = m_st; e_ls = 0; e_ea = 0; e_la = 0;
         lim = (m_st == 1) ? P_RELAY : (m_st == 2) ? P_HOLD : (m_st == 3) ? P_ERASE : P_TMO;
         due = ms_tick && (m_el + 1 >= lim);
         case (m_st)
            0: if (m_pr) nst = 2; else if (rx_valid) nst = 1;
            1: if (m_pr) nst = 2; else if (due) nst = 0;
            2: if (m_rl) nst = 0; else if (due) nst = 3;
            3: if (m_rl) begin nst = 5; e_ls = 1; end else if (due) begin nst = 4; e_ea = 1; end
            4: if (m_rl) nst = 0;
            5: if (m_pr) begin nst = 6; e_la = 1; end
               else if (lrn_code_bad) begin nst = 0; e_la = 1; end
               else if (lrn_code_ok && m_ok) nst = 0;
               else if (due) begin nst = 0; e_la = 1; end
            default: if (m_rl) nst = 0;
         endcase
         if (m_st != 5) m_ok = 0; else if (lrn_code_ok) m_ok = 1;
         if (nst != m_st) m_el = 0; else if (ms_tick) m_el++;
         m_st = nst;
         m_pr = 0; m_rl = 0;
         if (m_s2 == m_lvl) m_dc = 0;
         else if (ms_tick) begin
            if (m_dc + 1 >= P_DEB) begin
               m_lvl = m_s2; m_pr = m_s2; m_rl = !m_s2; m_dc = 0;
            end else m_dc++;
         end
         m_s2 = m_s1; m_s1 = btn_in;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (rst_n && !done) begin
      bit led_exp;
      led_exp = (m_st == 1) || (m_st == 2) || (m_st == 6);
      chk("R2/data_drive model", data_drive, led_exp);
      chk("R12 learn_start model", learn_start, e_ls);
      chk("R12 erase_all model", erase_all, e_ea);
      chk("R12 learn_abort model", learn_abort, e_la);
      if (learn_start) n_ls++;
      if (erase_all)   n_ea++;
      if (learn_abort) n_la++;
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic strobe(ref logic s);
      @(negedge clk); s = 1'b1;
      @(negedge clk); s = 1'b0;
   endtask

   task automatic hold(input int cycles);
      @(negedge clk); btn_in = 1'b1;
      cyc(cycles);
      btn_in = 1'b0;
      cyc(2 * P_DEB + 8);
   endtask

   task automatic reset_counts();
      n_ls = 0; n_ea = 0; n_la = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      cyc(3);
      chk("R12 reset learn_start", learn_start, 0);
      chk("R2 reset data_drive", data_drive, 0);
      rst_n = 1'b1;
      cyc(4);

      // R1: glitch shorter than the debounce window
      @(negedge clk); btn_in = 1'b1; cyc(3); btn_in = 1'b0;
      cyc(20);
      chk("R1 glitch ignored data_drive", data_drive, 0);

      // R2 / R3: short press
      reset_counts();
      @(negedge clk); btn_in = 1'b1;
      cyc(2 * P_DEB + 6);
      chk("R2 press lights LED", data_drive, 1);
      cyc(6);
      btn_in = 1'b0;
      cyc(2 * P_DEB + 8);
      chk("R3 short release LED off", data_drive, 0);
      chk("R3 short release no pulses", n_ls + n_ea + n_la, 0);

      // R6: relay pulse
      strobe(rx_valid);
      cyc(2);
      chk("R6 relay on", data_drive, 1);
      cyc(2 * P_RELAY + 4);
      chk("R6 relay off", data_drive, 0);

      // R4 / R7 / R11: learn, ignored strobe, two good codes
      reset_counts();
      @(negedge clk); btn_in = 1'b1;
      cyc(2 * P_DEB + 2 * P_HOLD + 10);
      chk("R4 armed LED off", data_drive, 0);
      btn_in = 1'b0;
      cyc(2 * P_DEB + 8);
      chk("R4 learn_start once", n_ls, 1);
      strobe(rx_valid);
      cyc(3);
      chk("R7 valid ignored in learn", data_drive, 0);
      strobe(lrn_code_ok);
      cyc(4);
      strobe(lrn_code_ok);
      cyc(4);
      chk("R11 no abort on success", n_la, 0);
      strobe(rx_valid);
      cyc(2);
      chk("R11 relay after learn", data_drive, 1);
      cyc(2 * P_RELAY + 4);

      // R9: bad code
      reset_counts();
      hold(2 * P_DEB + 2 * P_HOLD + 10);
      strobe(lrn_code_bad);
      cyc(3);
      chk("R9 abort on bad code", n_la, 1);

      // R10: timeout after a single good code
      reset_counts();
      hold(2 * P_DEB + 2 * P_HOLD + 10);
      strobe(lrn_code_ok);
      cyc(2 * P_TMO + 10);
      chk("R10 abort on timeout", n_la, 1);

      // R8: press during learn
      reset_counts();
      hold(2 * P_DEB + 2 * P_HOLD + 10);
      @(negedge clk); btn_in = 1'b1;
      cyc(2 * P_DEB + 8);
      chk("R8 abort on press", n_la, 1);
      chk("R8 LED on until release", data_drive, 1);
      btn_in = 1'b0;
      cyc(2 * P_DEB + 8);
      chk("R8 LED off after release", data_drive, 0);

      // R5: erase-all on long hold
      reset_counts();
      hold(2 * P_DEB + 2 * P_HOLD + 2 * P_ERASE + 12);
      chk("R5 erase_all once", n_ea, 1);
      chk("R5 no learn after erase", n_ls, 0);
      chk("R5 LED off", data_drive, 0);

      cyc(4);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule